// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers 64 external interrupt lines and drives two request outputs toward a processor: an ordinary request and a fast request. The sources are handled in two groups of 32. Every group has two register banks of its own, one feeding the ordinary output and one feeding the fast output. Each bank has its own per-source enable, edge-or-level choice and polarity choice. Inputs are first resynchronized to the block clock. Then every bank detects them by its own settings.

Software reaches the banks over a simple 32-bit bus with single-cycle access. A write is taken at the clock edge. A read returns data in the same cycle, combinationally. The bank at byte offset 0x00 serves ordinary requests for sources 0-31, 0x20 serves fast requests for 0-31, 0x60 serves ordinary requests for 32-63, and 0x80 serves fast requests for 32-63. A read-only revision word sits at 0x50 and a read-only capability word at 0x54. Within a bank, the word at offset +0x00 shows the synchronized inputs. The other words are:

| Offset | Word |
|--------|------|
| +0x04 | enable |
| +0x08 | clear, write-one |
| +0x0C | mode |
| +0x10 | polarity |
| +0x14 | masked status |

The block has no sequencing state: each bank is a set of registers plus a pending latch for every bit.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, every enable, mode and polarity word reads 0, every status word reads 0, and both request outputs are 0.
- R2: Enable (+0x04), mode (+0x0C) and polarity (+0x10) in each of the four banks (bases 0x00, 0x20, 0x60, 0x80) read back what was written. Offset 0x50 reads the revision parameter. Offset 0x54 reads the capability word 0x00000140: bit 8 set for the fast output, low byte equal to the source count.
- R3: The raw word (+0x00) of a group shows its inputs after a two-flop synchronizer. An input changed between clock edges is still old after the first edge and visible after the second.
- R4: With mode bit 0 and polarity bit 0, an enabled source's status bit (+0x14) equals its synchronized input, active high. A clear write does not affect it.
- R5: With mode bit 0 and polarity bit 1, an enabled source's status bit is set while the synchronized input is low.
- R6: With mode bit 1 and polarity bit 0, a rising edge of an enabled source sets a pending bit. The bit stays set after the input falls, until it is cleared.
- R7: With mode bit 1 and polarity bit 1, a falling edge sets the pending bit and a rising edge does not.
- R8: Writing 1 to a bit of the clear word (+0x08) clears that pending bit, and writing 0 leaves it. If a new edge is detected in the same cycle as the clear, the bit stays set.
- R9: A source whose enable bit is 0 shows 0 in status and does not drive an output. An edge seen while disabled is not latched. Clearing the enable bit removes the status at once.
- R10: The ordinary output is the OR of the two ordinary status words, and the fast output is the OR of the two fast status words. The two banks of a group act independently on the same inputs.
- R11: Reserved offsets read 0: 0x40-0x4C, 0x58-0x5C, +0x18/+0x1C in each bank, and 0xA0 upward. Writes to them, and to the read-only words, change nothing. The clear word reads 0.
- R12: Source n in 32..63 appears at bit n-32 of the banks at 0x60 and 0x80 and not in the low-group banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Asynchronous interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| norm_irq_o | output | 1 | Ordinary interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
Level detection is tried with a held-high input and a held-low input under each polarity. Edge detection uses short pulses that return to idle before the status is read, which shows a latched bit apart from a followed level. One edge is timed so that its detection cycle meets a clear write. This tells the edge-wins priority apart from a plain clear. Sources are driven both in the low group and in the high group, with one bank of a pair enabled and its twin not, which exposes bank crosstalk and wrong bit mapping.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
    localparam int GRP_W   = 32;
    localparam int NUM_GRP = 2;

    typedef enum logic [2:0] {
        WI_RAW  = 3'd0,
        WI_EN   = 3'd1,
        WI_CLR  = 3'd2,
        WI_MODE = 3'd3,
        WI_POL  = 3'd4,
        WI_STAT = 3'd5,
        WI_RSV6 = 3'd6,
        WI_RSV7 = 3'd7
    } word_idx_e;

    localparam logic [2:0] SLOT_MISC = 3'd2;
    localparam logic [2:0] MISC_REV  = 3'd4;
    localparam logic [2:0] MISC_CAP  = 3'd5;
endpackage

// File: rtl/dbic_sync.sv
module dbic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign prev_o = prev_q;

    generate
        if (STAGES >= 2) begin : g_chk
            // R3: last stage takes the previous stage one edge later
            assert_sync_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stg_q[STAGES-1] == $past(stg_q[STAGES-2])));
        end
    endgenerate
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank
    import dbic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic         wr_i,
    input  logic [2:0]   idx_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] status_o
);
    logic [W-1:0] en_q, mode_q, pol_q, pend_q;
    logic [W-1:0] edge_seen, edge_hit, clr_mask, lvl_active;

    assign edge_seen  = (sync_i & ~prev_i & ~pol_q) | (~sync_i & prev_i & pol_q);
    assign edge_hit   = edge_seen & en_q & mode_q;
    assign clr_mask   = (wr_i && idx_i == WI_CLR) ? wdata_i : '0;
    assign lvl_active = sync_i ^ pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | edge_hit;
            if (wr_i) begin
                unique case (idx_i)
                    WI_EN:   en_q   <= wdata_i;
                    WI_MODE: mode_q <= wdata_i;
                    WI_POL:  pol_q  <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    assign status_o = en_q & ((mode_q & pend_q) | (~mode_q & lvl_active));

    always_comb begin
        unique case (idx_i)
            WI_RAW:  rdata_o = sync_i;
            WI_EN:   rdata_o = en_q;
            WI_MODE: rdata_o = mode_q;
            WI_POL:  rdata_o = pol_q;
            WI_STAT: rdata_o = status_o;
            default: rdata_o = '0;
        endcase
    end

    // R8: a detected edge is latched even under a clear of the same bit
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));
    // R8: cleared bits without a new edge are gone next cycle
    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pend_q & $past(clr_mask & ~edge_hit)) == '0));
    // R6: pending bits persist unless cleared
    assert_pend_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask)));
    // R9: nothing enabled, nothing reported
    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (status_o == '0));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import dbic_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] REV_WORD    = 32'h0001_0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] src_i,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        norm_irq_o,
    output logic        fast_irq_o
);
    localparam int          NUM_SRC = GRP_W * NUM_GRP;
    localparam int          NB      = NUM_GRP * 2;
    localparam logic [31:0] CAP_WORD = 32'h100 | 32'(NUM_SRC);

    logic [2:0] slot, idx;
    assign slot = bus_addr[7:5];
    assign idx  = bus_addr[4:2];

    logic [GRP_W-1:0] sync_w [NUM_GRP];
    logic [GRP_W-1:0] prev_w [NUM_GRP];
    logic [GRP_W-1:0] rd_w   [NB];
    logic [GRP_W-1:0] stat_w [NB];
    logic [NB-1:0]    hit;
    logic [NB-1:0]    stat_any;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            dbic_sync #(.W(GRP_W), .STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .async_i(src_i[g*GRP_W +: GRP_W]),
                .sync_o (sync_w[g]),
                .prev_o (prev_w[g])
            );
            for (genvar k = 0; k < 2; k++) begin : g_kind
                localparam int          B    = g*2 + k;
                localparam logic [2:0]  SLOT = 3'(g*3 + k);
                assign hit[B] = (slot == SLOT);
                dbic_bank #(.W(GRP_W)) u_bank (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .sync_i  (sync_w[g]),
                    .prev_i  (prev_w[g]),
                    .wr_i    (bus_sel && bus_wr && hit[B]),
                    .idx_i   (idx),
                    .wdata_i (bus_wdata),
                    .rdata_o (rd_w[B]),
                    .status_o(stat_w[B])
                );
                assign stat_any[B] = |stat_w[B];
            end
        end
    endgenerate

    logic rsvd_hit;
    assign rsvd_hit = (hit == '0) &&
                      !(slot == SLOT_MISC && (idx == MISC_REV || idx == MISC_CAP));

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int b = 0; b < NB; b++)
                if (hit[b]) bus_rdata = rd_w[b];
            if (slot == SLOT_MISC && idx == MISC_REV) bus_rdata = REV_WORD;
            if (slot == SLOT_MISC && idx == MISC_CAP) bus_rdata = CAP_WORD;
        end
    end

    always_comb begin
        norm_irq_o = 1'b0;
        fast_irq_o = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            norm_irq_o = norm_irq_o | stat_any[g*2];
            fast_irq_o = fast_irq_o | stat_any[g*2+1];
        end
    end

    // R11: reserved space reads as zero
    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && rsvd_hit) |-> (bus_rdata == '0));
    // R10: a request output implies some bank of its kind reports status
    assert_norm_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        norm_irq_o |-> ((stat_w[0] | stat_w[2]) != '0));
    assert_fast_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_irq_o |-> ((stat_w[1] | stat_w[3]) != '0));
endmodule

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/1ps
module dual_bank_intc_bench;
    localparam logic [31:0] REV = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nirq, firq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_bank_intc #(.REV_WORD(REV)) u_dual_bank_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .norm_irq_o(nirq), .fast_irq_o(firq)
    );

    function automatic logic [7:0] base(int g, int k);
        return 8'(g*8'h60 + k*8'h20);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        sel = 0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            rreg(base(b/2, b%2) + 8'h04, d); chk("R1 enable", d, 0);
            rreg(base(b/2, b%2) + 8'h0C, d); chk("R1 mode", d, 0);
            rreg(base(b/2, b%2) + 8'h10, d); chk("R1 polarity", d, 0);
            rreg(base(b/2, b%2) + 8'h14, d); chk("R1 status", d, 0);
        end
        chk("R1 outputs", {30'd0, nirq, firq}, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            wreg(base(b/2, b%2) + 8'h04, 32'hA5A5_0000 + b);
            wreg(base(b/2, b%2) + 8'h0C, 32'h0F0F_1000 + b);
            wreg(base(b/2, b%2) + 8'h10, 32'h3C3C_2000 + b);
        end
        for (int b = 0; b < 4; b++) begin
            rreg(base(b/2, b%2) + 8'h04, d); chk("R2 enable rb", d, 32'hA5A5_0000 + b);
            rreg(base(b/2, b%2) + 8'h0C, d); chk("R2 mode rb", d, 32'h0F0F_1000 + b);
            rreg(base(b/2, b%2) + 8'h10, d); chk("R2 polarity rb", d, 32'h3C3C_2000 + b);
            wreg(base(b/2, b%2) + 8'h04, 0);
            wreg(base(b/2, b%2) + 8'h0C, 0);
            wreg(base(b/2, b%2) + 8'h10, 0);
            wreg(base(b/2, b%2) + 8'h08, 32'hFFFF_FFFF);
        end
        rreg(8'h50, d); chk("R2 revision", d, REV);
        rreg(8'h54, d); chk("R2 capability", d, 32'h0000_0140);
    endtask

    task automatic t_raw;
        logic [31:0] d;
        @(negedge clk); src[0] = 1;
        tick(1); peek(8'h00, d); chk("R3 raw after one edge", d & 1, 0);
        tick(1); peek(8'h00, d); chk("R3 raw after two edges", d & 1, 1);
        src[0] = 0; tick(3);
    endtask

    task automatic t_level_hi;
        logic [31:0] d;
        wreg(8'h04, 32'h8);
        @(negedge clk); src[3] = 1;
        tick(2); peek(8'h14, d); chk("R4 level high status", d, 32'h8);
        chk("R10 ordinary out only", {30'd0, nirq, firq}, 2);
        wreg(8'h08, 32'hFFFF_FFFF);
        rreg(8'h14, d); chk("R4 clear ignored in level", d, 32'h8);
        @(negedge clk); src[3] = 0;
        tick(2); peek(8'h14, d); chk("R4 level follows low", d, 0);
        wreg(8'h04, 0);
    endtask

    task automatic t_level_lo;
        logic [31:0] d;
        wreg(8'h10, 32'h20);
        wreg(8'h04, 32'h20);
        tick(1); peek(8'h14, d); chk("R5 active low idle", d, 32'h20);
        @(negedge clk); src[5] = 1;
        tick(2); peek(8'h14, d); chk("R5 active low high input", d, 0);
        src[5] = 0;
        wreg(8'h04, 0); wreg(8'h10, 0);
    endtask

    task automatic t_edge_rise;
        logic [31:0] d;
        wreg(8'h0C, 32'h80); wreg(8'h04, 32'h80);
        @(negedge clk); src[7] = 1;
        tick(1); src[7] = 0;
        tick(5); peek(8'h14, d); chk("R6 rising edge latched", d, 32'h80);
        wreg(8'h08, 32'h0);
        rreg(8'h14, d); chk("R8 zero clear keeps", d, 32'h80);
        wreg(8'h08, 32'h80);
        rreg(8'h14, d); chk("R8 one clear removes", d, 0);
        chk("R8 output drops", {31'd0, nirq}, 0);
        wreg(8'h04, 0); wreg(8'h0C, 0);
    endtask

    task automatic t_edge_fall;
        logic [31:0] d;
        wreg(8'h0C, 32'h200); wreg(8'h10, 32'h200); wreg(8'h04, 32'h200);
        @(negedge clk); src[9] = 1;
        tick(5); peek(8'h14, d); chk("R7 rising ignored", d, 0);
        src[9] = 0;
        tick(5); peek(8'h14, d); chk("R7 falling latched", d, 32'h200);
        wreg(8'h08, 32'h200);
        wreg(8'h04, 0); wreg(8'h0C, 0); wreg(8'h10, 0);
    endtask

    task automatic t_race;
        logic [31:0] d;
        wreg(8'h0C, 32'h1000); wreg(8'h04, 32'h1000);
        @(negedge clk); src[12] = 1;
        tick(2);
        sel = 1; wr = 1; addr = 8'h08; wdata = 32'h1000;
        @(negedge clk); sel = 0; wr = 0;
        peek(8'h14, d); chk("R8 edge beats same-cycle clear", d, 32'h1000);
        wreg(8'h08, 32'h1000);
        rreg(8'h14, d); chk("R8 later clear works", d, 0);
        src[12] = 0; tick(3);
        wreg(8'h08, 32'h1000);
        wreg(8'h04, 0); wreg(8'h0C, 0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        @(negedge clk); src[14] = 1;
        tick(3); peek(8'h14, d); chk("R9 disabled level hidden", d, 0);
        chk("R9 disabled no output", {31'd0, nirq}, 0);
        wreg(8'h04, 32'h4000);
        peek(8'h14, d); chk("R9 enable shows level", d, 32'h4000);
        wreg(8'h04, 0);
        peek(8'h14, d); chk("R9 disable removes status", d, 0);
        src[14] = 0;
        wreg(8'h0C, 32'h8000);
        @(negedge clk); src[15] = 1;
        tick(1); src[15] = 0;
        tick(4);
        wreg(8'h04, 32'h8000);
        peek(8'h14, d); chk("R9 edge while disabled dropped", d, 0);
        wreg(8'h04, 0); wreg(8'h0C, 0);
    endtask

    task automatic t_fast;
        logic [31:0] d;
        wreg(8'h24, 32'h4);
        @(negedge clk); src[2] = 1;
        tick(2); peek(8'h34, d); chk("R10 fast status", d, 32'h4);
        peek(8'h14, d); chk("R10 ordinary twin idle", d, 0);
        chk("R10 fast out only", {30'd0, nirq, firq}, 1);
        wreg(8'h04, 32'h4);
        chk("R10 both outputs", {30'd0, nirq, firq}, 3);
        src[2] = 0; tick(3);
        chk("R10 outputs fall", {30'd0, nirq, firq}, 0);
        wreg(8'h24, 0); wreg(8'h04, 0);
    endtask

    task automatic t_high;
        logic [31:0] d;
        wreg(8'h64, 32'h100); wreg(8'h04, 32'h100);
        @(negedge clk); src[40] = 1;
        tick(2); peek(8'h60, d); chk("R12 high raw bit", d, 32'h100);
        peek(8'h00, d); chk("R12 low raw clean", d, 0);
        peek(8'h74, d); chk("R12 high status bit", d, 32'h100);
        peek(8'h14, d); chk("R12 low status clean", d, 0);
        src[40] = 0;
        wreg(8'h84, 32'h8000_0000);
        @(negedge clk); src[63] = 1;
        tick(2); peek(8'h94, d); chk("R12 fast high top bit", d, 32'h8000_0000);
        chk("R12 fast out", {31'd0, firq}, 1);
        src[63] = 0; tick(3);
        wreg(8'h64, 0); wreg(8'h04, 0); wreg(8'h84, 0);
    endtask

    task automatic t_rsvd;
        logic [31:0] d;
        wreg(8'h40, 32'hFFFF_FFFF); wreg(8'h18, 32'hFFFF_FFFF);
        wreg(8'h58, 32'hFFFF_FFFF); wreg(8'hA4, 32'hFFFF_FFFF);
        wreg(8'hE4, 32'hFFFF_FFFF); wreg(8'h50, 32'hFFFF_FFFF);
        wreg(8'h14, 32'hFFFF_FFFF);
        rreg(8'h40, d); chk("R11 reserved 0x40", d, 0);
        rreg(8'h18, d); chk("R11 bank reserved", d, 0);
        rreg(8'h5C, d); chk("R11 reserved 0x5C", d, 0);
        rreg(8'hA4, d); chk("R11 beyond map", d, 0);
        rreg(8'h50, d); chk("R11 revision unwritable", d, REV);
        rreg(8'h08, d); chk("R11 clear word reads zero", d, 0);
        for (int b = 0; b < 4; b++) begin
            rreg(base(b/2, b%2) + 8'h04, d); chk("R11 enables untouched", d, 0);
            rreg(base(b/2, b%2) + 8'h14, d); chk("R11 status untouched", d, 0);
        end
        chk("R11 outputs quiet", {30'd0, nirq, firq}, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset;
        t_regmap;
        t_raw;
        t_level_hi;
        t_level_lo;
        t_edge_rise;
        t_edge_fall;
        t_race;
        t_enable;
        t_fast;
        t_high;
        t_rsvd;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule